// File: doc/BRIEF.md
# Windowed Trap Entry Unit

This block performs the state transition that a 32-bit register-windowed processor makes when it enters a trap or accepts an external interrupt. It has a single trap level and no trap stack. Each cycle it samples a synchronous trap request with its trap type, the current processor status fields (traps-enabled flag, supervisor flag, window pointer, interrupt mask level), the trap base register and the program counters. One cycle later it presents the committed post-trap state together with two register-file write pulses. Those pulses save the interrupted PC and nPC into the local registers of the freshly rotated window.

External interrupt requests carry a 4-bit level. A request is latched as a pending interrupt index and is accepted once traps are enabled and its level clears the mask level, with level 15 always passing the mask. If a synchronous trap arrives while traps are disabled, the unit does not service it. It enters a sticky error state that only reset leaves.

The surrounding pipeline feeds the committed state back as its architectural state. It forwards the write pulses to the windowed register file.

Top module: `trap_entry_unit`

## Requirements
- R1: A synchronous trap presented while `cur_et_i` is 0 is not taken. `err_o` rises in the next cycle and stays high until reset. While `err_o` is high, no trap or interrupt is taken and the committed state outputs hold.
- R2: On a taken trap, `nxt_et_o` is 0 and `nxt_cwp_o` is `cur_cwp_i - 1` modulo NWIN, so window 0 wraps to NWIN-1.
- R3: On a taken trap, both bits of `rf_we_o` are 1 in the same cycle as `take_o`. Port 0 writes the old PC to address `{new_cwp, 4'd9}` and port 1 writes the old nPC to `{new_cwp, 4'd10}` (locals start at slot 8 of a 16-slot window). `rf_we_o` is 0 in every other cycle.
- R4: On a taken trap, `nxt_ps_o` takes the old `cur_s_i` and `nxt_s_o` becomes 1.
- R5: On a taken trap, `nxt_tbr_o[XLEN-1:12]` keeps `cur_tbr_i[XLEN-1:12]`, bits 11:4 hold the 8-bit trap type, and bits 3:0 are 0.
- R6: On a taken trap, `nxt_pc_o` equals `nxt_tbr_o` and `nxt_npc_o` equals `nxt_pc_o + 4`.
- R7: An interrupt request of level n (1..15) is latched as pending index `0x10 | n`, and a request of level 0 is ignored. The pending interrupt is taken only while `cur_et_i` is 1 and either n is 15 or n is greater than `pil_i`. Otherwise it stays pending.
- R8: Accepting an interrupt sets `exc_idx_o` to the pending index and pulses `irq_ack_o` for one cycle. `pend_idx_o` returns to 0.
- R9: A synchronous trap with traps enabled is taken regardless of `pil_i` and wins over a pending interrupt, which stays pending and may be taken afterwards.
- R10: All results are registered and appear one cycle after the inputs are sampled. A latched interrupt is evaluated from the following cycle on. Reset gives `nxt_et_o`=1, `nxt_s_o`=1, `nxt_ps_o`=1, `nxt_cwp_o`=0, `nxt_pc_o`=0, `nxt_npc_o`=4, `err_o`=0, `pend_idx_o`=0 and no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trap_valid_i | input | 1 | Synchronous trap request |
| trap_type_i | input | 8 | Trap type of the synchronous trap |
| irq_req_i | input | 1 | External interrupt request strobe |
| irq_level_i | input | 4 | Level of the interrupt request |
| pil_i | input | 4 | Current interrupt mask level |
| cur_et_i | input | 1 | Current traps-enabled flag |
| cur_s_i | input | 1 | Current supervisor flag |
| cur_cwp_i | input | CWP_W | Current window pointer |
| cur_tbr_i | input | XLEN | Current trap base register |
| cur_pc_i | input | XLEN | Current PC |
| cur_npc_i | input | XLEN | Current nPC |
| take_o | output | 1 | One-cycle pulse: a trap was entered |
| irq_ack_o | output | 1 | One-cycle pulse: interrupt accepted, hard request cleared |
| err_o | output | 1 | Sticky error state |
| exc_idx_o | output | 8 | Trap type of the last entered trap |
| pend_idx_o | output | 8 | Pending interrupt index, 0 when none |
| nxt_et_o | output | 1 | Committed traps-enabled flag |
| nxt_s_o | output | 1 | Committed supervisor flag |
| nxt_ps_o | output | 1 | Committed previous-supervisor flag |
| nxt_cwp_o | output | CWP_W | Committed window pointer |
| nxt_tbr_o | output | XLEN | Committed trap base register |
| nxt_pc_o | output | XLEN | Committed PC |
| nxt_npc_o | output | XLEN | Committed nPC |
| rf_we_o | output | 2 | Register-file write enables, one per save port |
| rf_addr0_o | output | CWP_W+4 | Save port 0 address (PC) |
| rf_data0_o | output | XLEN | Save port 0 data (PC) |
| rf_addr1_o | output | CWP_W+4 | Save port 1 address (nPC) |
| rf_data1_o | output | XLEN | Save port 1 data (nPC) |

## Verification
The bench builds two copies of the unit from the same stimulus: one with NWIN=8 and one with NWIN=5, both with XLEN=32. The power-of-two copy takes the plain modulo-subtract path for the window pointer. The five-window copy forces the compare-and-wrap variant, so the wrap from window 0 to window 4 is checked alongside the wrap to window 7. The save-port addresses are checked in both 3-bit window encodings.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam int TT_W      = 8;
  localparam int LVL_W     = 4;
  localparam int SLOT_W    = 4;   // 16 slots per window
  localparam int LOCAL_OFS = 8;   // locals start at slot 8
  localparam int TBR_LO    = 12;  // base field starts here
  localparam logic [TT_W-LVL_W-1:0] IRQ_TT_HI = 'h1;
  localparam logic [LVL_W-1:0]      LVL_NMI   = '1;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_IRQ   = 2'd2,
    SRC_FAULT = 2'd3
  } trap_src_e;
endpackage

// File: rtl/trap_accept.sv
module trap_accept
  import trap_entry_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_valid_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] pil_i,
  input  logic             et_i,
  input  logic             err_i,
  output trap_src_e        src_o,
  output logic [TT_W-1:0]  tt_o,
  output logic [TT_W-1:0]  pend_idx_o
);
  logic [TT_W-1:0]  pend_q;
  logic [LVL_W-1:0] pend_lvl;
  logic             pend_vld, irq_ok;

  assign pend_lvl = pend_q[LVL_W-1:0];
  assign pend_vld = (pend_q[TT_W-1:LVL_W] == IRQ_TT_HI) && (pend_lvl != '0);
  assign irq_ok   = pend_vld && et_i && ((pend_lvl == LVL_NMI) || (pend_lvl > pil_i));

  always_comb begin
    src_o = SRC_NONE;
    if (!err_i) begin
      if (trap_valid_i) src_o = et_i ? SRC_SYNC : SRC_FAULT;
      else if (irq_ok)  src_o = SRC_IRQ;
    end
  end

  assign tt_o = trap_valid_i ? trap_type_i : pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
    end else if (irq_req_i && (irq_level_i != '0)) begin
      pend_q <= {IRQ_TT_HI, irq_level_i};
    end else if (src_o == SRC_IRQ) begin
      pend_q <= '0;
    end
  end

  assign pend_idx_o = pend_q;
endmodule

// File: rtl/trap_commit.sv
module trap_commit
  import trap_entry_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int XLEN  = 32,
  parameter int CWP_W = 3
) (
  input  logic [TT_W-1:0]  tt_i,
  input  logic [CWP_W-1:0] cwp_i,
  input  logic [XLEN-1:0]  tbr_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [XLEN-1:0]  tbr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  npc_o
);
  localparam bit POW2 = (NWIN & (NWIN - 1)) == 0;
  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NWIN - 1);

  generate
    if (POW2) begin : g_pow2
      assign cwp_o = cwp_i - CWP_W'(1);
    end else begin : g_wrap
      assign cwp_o = (cwp_i == '0) ? LAST_WIN : cwp_i - CWP_W'(1);
    end
  endgenerate

  assign tbr_o = {tbr_i[XLEN-1:TBR_LO], tt_i, 4'b0000};
  assign pc_o  = tbr_o;
  assign npc_o = tbr_o + XLEN'(4);
endmodule

// File: rtl/trap_save_port.sv
module trap_save_port
  import trap_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CWP_W = 3,
  parameter int AW    = CWP_W + SLOT_W
) (
  input  logic [CWP_W-1:0]         cwp_i,
  input  logic [XLEN-1:0]          pc_i,
  input  logic [XLEN-1:0]          npc_i,
  output logic [1:0][AW-1:0]       addr_o,
  output logic [1:0][XLEN-1:0]     data_o
);
  logic [1:0][XLEN-1:0] src;
  assign src[0] = pc_i;
  assign src[1] = npc_i;

  for (genvar k = 0; k < 2; k++) begin : g_port
    assign addr_o[k] = {cwp_i, SLOT_W'(LOCAL_OFS + 1 + k)};
    assign data_o[k] = src[k];
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_entry_pkg::*;
#(
  parameter  int NWIN  = 8,
  parameter  int XLEN  = 32,
  localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int AW    = CWP_W + SLOT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trap_valid_i,
  input  logic [TT_W-1:0]  trap_type_i,
  input  logic             irq_req_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [LVL_W-1:0] pil_i,
  input  logic             cur_et_i,
  input  logic             cur_s_i,
  input  logic [CWP_W-1:0] cur_cwp_i,
  input  logic [XLEN-1:0]  cur_tbr_i,
  input  logic [XLEN-1:0]  cur_pc_i,
  input  logic [XLEN-1:0]  cur_npc_i,
  output logic             take_o,
  output logic             irq_ack_o,
  output logic             err_o,
  output logic [TT_W-1:0]  exc_idx_o,
  output logic [TT_W-1:0]  pend_idx_o,
  output logic             nxt_et_o,
  output logic             nxt_s_o,
  output logic             nxt_ps_o,
  output logic [CWP_W-1:0] nxt_cwp_o,
  output logic [XLEN-1:0]  nxt_tbr_o,
  output logic [XLEN-1:0]  nxt_pc_o,
  output logic [XLEN-1:0]  nxt_npc_o,
  output logic [1:0]       rf_we_o,
  output logic [AW-1:0]    rf_addr0_o,
  output logic [XLEN-1:0]  rf_data0_o,
  output logic [AW-1:0]    rf_addr1_o,
  output logic [XLEN-1:0]  rf_data1_o
);
  trap_src_e            src;
  logic [TT_W-1:0]      tt;
  logic [CWP_W-1:0]     cwp_n;
  logic [XLEN-1:0]      tbr_n, pc_n, npc_n;
  logic [1:0][AW-1:0]   sv_addr;
  logic [1:0][XLEN-1:0] sv_data;
  logic                 enter;

  trap_accept i_accept (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trap_valid_i (trap_valid_i),
    .trap_type_i  (trap_type_i),
    .irq_req_i    (irq_req_i),
    .irq_level_i  (irq_level_i),
    .pil_i        (pil_i),
    .et_i         (cur_et_i),
    .err_i        (err_o),
    .src_o        (src),
    .tt_o         (tt),
    .pend_idx_o   (pend_idx_o)
  );

  trap_commit #(.NWIN(NWIN), .XLEN(XLEN), .CWP_W(CWP_W)) i_commit (
    .tt_i  (tt),
    .cwp_i (cur_cwp_i),
    .tbr_i (cur_tbr_i),
    .cwp_o (cwp_n),
    .tbr_o (tbr_n),
    .pc_o  (pc_n),
    .npc_o (npc_n)
  );

  trap_save_port #(.XLEN(XLEN), .CWP_W(CWP_W), .AW(AW)) i_save (
    .cwp_i  (cwp_n),
    .pc_i   (cur_pc_i),
    .npc_i  (cur_npc_i),
    .addr_o (sv_addr),
    .data_o (sv_data)
  );

  assign enter = (src == SRC_SYNC) || (src == SRC_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_o     <= 1'b0;
      irq_ack_o  <= 1'b0;
      err_o      <= 1'b0;
      rf_we_o    <= '0;
    end else begin
      take_o     <= enter;
      irq_ack_o  <= (src == SRC_IRQ);
      err_o      <= err_o | (src == SRC_FAULT);
      rf_we_o    <= {2{enter}};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_idx_o  <= '0;
      nxt_et_o   <= 1'b1;
      nxt_s_o    <= 1'b1;
      nxt_ps_o   <= 1'b1;
      nxt_cwp_o  <= '0;
      nxt_tbr_o  <= '0;
      nxt_pc_o   <= '0;
      nxt_npc_o  <= XLEN'(4);
      rf_addr0_o <= '0;
      rf_data0_o <= '0;
      rf_addr1_o <= '0;
      rf_data1_o <= '0;
    end else if (enter) begin
      exc_idx_o  <= tt;
      nxt_et_o   <= 1'b0;
      nxt_s_o    <= 1'b1;
      nxt_ps_o   <= cur_s_i;
      nxt_cwp_o  <= cwp_n;
      nxt_tbr_o  <= tbr_n;
      nxt_pc_o   <= pc_n;
      nxt_npc_o  <= npc_n;
      rf_addr0_o <= sv_addr[0];
      rf_data0_o <= sv_data[0];
      rf_addr1_o <= sv_addr[1];
      rf_data1_o <= sv_data[1];
    end
  end
endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker
  import trap_entry_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int CWP_W = 3,
  parameter int AW    = CWP_W + SLOT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [LVL_W-1:0] pil_i,
  input logic [CWP_W-1:0] cur_cwp_i,
  input logic             take_o,
  input logic             irq_ack_o,
  input logic             err_o,
  input logic [TT_W-1:0]  exc_idx_o,
  input logic [TT_W-1:0]  pend_idx_o,
  input logic             nxt_et_o,
  input logic             nxt_s_o,
  input logic [CWP_W-1:0] nxt_cwp_o,
  input logic [XLEN-1:0]  nxt_tbr_o,
  input logic [XLEN-1:0]  nxt_pc_o,
  input logic [XLEN-1:0]  nxt_npc_o,
  input logic [1:0]       rf_we_o,
  input logic [AW-1:0]    rf_addr0_o,
  input logic [AW-1:0]    rf_addr1_o
);
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R1
  AST_ERR_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !take_o); // R1
  AST_TAKE_ET_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> !nxt_et_o); // R2
  AST_WIN_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> nxt_cwp_o != $past(cur_cwp_i)); // R2
  AST_SAVE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we_o != 2'b00) |-> (take_o && rf_we_o == 2'b11)); // R3
  AST_SAVE_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (rf_addr0_o[AW-1:SLOT_W] == nxt_cwp_o && rf_addr1_o[AW-1:SLOT_W] == nxt_cwp_o)); // R3
  AST_SUPER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> nxt_s_o); // R4
  AST_TBR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> nxt_tbr_o[3:0] == 4'h0); // R5
  AST_PC_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (nxt_pc_o == nxt_tbr_o && nxt_npc_o == nxt_pc_o + XLEN'(4))); // R6
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (exc_idx_o[LVL_W-1:0] == LVL_NMI || exc_idx_o[LVL_W-1:0] > $past(pil_i))); // R7
  AST_ACK_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> (take_o && exc_idx_o[TT_W-1:LVL_W] == IRQ_TT_HI)); // R8
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |=> !irq_ack_o || pend_idx_o == '0 || $past(pend_idx_o) == '0); // R8
endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN), .CWP_W(CWP_W), .AW(AW)) i_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pil_i      (pil_i),
  .cur_cwp_i  (cur_cwp_i),
  .take_o     (take_o),
  .irq_ack_o  (irq_ack_o),
  .err_o      (err_o),
  .exc_idx_o  (exc_idx_o),
  .pend_idx_o (pend_idx_o),
  .nxt_et_o   (nxt_et_o),
  .nxt_s_o    (nxt_s_o),
  .nxt_cwp_o  (nxt_cwp_o),
  .nxt_tbr_o  (nxt_tbr_o),
  .nxt_pc_o   (nxt_pc_o),
  .nxt_npc_o  (nxt_npc_o),
  .rf_we_o    (rf_we_o),
  .rf_addr0_o (rf_addr0_o),
  .rf_addr1_o (rf_addr1_o)
);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tv = 1'b0;
  logic [7:0]  ttype = '0;
  logic        irq = 1'b0;
  logic [3:0]  lvl = '0;
  logic [3:0]  pil = '0;
  logic        et = 1'b1;
  logic        s = 1'b0;
  logic [2:0]  cwp = '0;
  logic [31:0] tbr = '0;
  logic [31:0] pc = '0;
  logic [31:0] npc = '0;

  always #2 clk = ~clk;

  typedef struct {
    int          due;
    string       tag;
    logic        take, ack, err, et, s, ps;
    logic [7:0]  exc, pend;
    logic [2:0]  cwp8, cwp5;
    logic [31:0] tbr, pc, npc, d0, d1;
    logic [1:0]  we;
  } exp_t;

  // outputs of both instances
  logic        a_take, a_ack, a_err, a_et, a_s, a_ps, b_take, b_ack, b_err, b_et, b_s, b_ps;
  logic [7:0]  a_exc, a_pend, b_exc, b_pend;
  logic [2:0]  a_cwp, b_cwp;
  logic [31:0] a_tbr, a_pc, a_npc, a_d0, a_d1, b_tbr, b_pc, b_npc, b_d0, b_d1;
  logic [1:0]  a_we, b_we;
  logic [6:0]  a_ad0, a_ad1, b_ad0, b_ad1;

  trap_entry_unit #(.NWIN(8), .XLEN(32)) i_trap_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_type_i(ttype),
    .irq_req_i(irq), .irq_level_i(lvl), .pil_i(pil), .cur_et_i(et), .cur_s_i(s),
    .cur_cwp_i(cwp), .cur_tbr_i(tbr), .cur_pc_i(pc), .cur_npc_i(npc),
    .take_o(a_take), .irq_ack_o(a_ack), .err_o(a_err), .exc_idx_o(a_exc),
    .pend_idx_o(a_pend), .nxt_et_o(a_et), .nxt_s_o(a_s), .nxt_ps_o(a_ps),
    .nxt_cwp_o(a_cwp), .nxt_tbr_o(a_tbr), .nxt_pc_o(a_pc), .nxt_npc_o(a_npc),
    .rf_we_o(a_we), .rf_addr0_o(a_ad0), .rf_data0_o(a_d0), .rf_addr1_o(a_ad1),
    .rf_data1_o(a_d1));

  trap_entry_unit #(.NWIN(5), .XLEN(32)) i_trap_entry_unit_w5 (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(tv), .trap_type_i(ttype),
    .irq_req_i(irq), .irq_level_i(lvl), .pil_i(pil), .cur_et_i(et), .cur_s_i(s),
    .cur_cwp_i(cwp), .cur_tbr_i(tbr), .cur_pc_i(pc), .cur_npc_i(npc),
    .take_o(b_take), .irq_ack_o(b_ack), .err_o(b_err), .exc_idx_o(b_exc),
    .pend_idx_o(b_pend), .nxt_et_o(b_et), .nxt_s_o(b_s), .nxt_ps_o(b_ps),
    .nxt_cwp_o(b_cwp), .nxt_tbr_o(b_tbr), .nxt_pc_o(b_pc), .nxt_npc_o(b_npc),
    .rf_we_o(b_we), .rf_addr0_o(b_ad0), .rf_data0_o(b_d0), .rf_addr1_o(b_ad1),
    .rf_data1_o(b_d1));

  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  // reference model state
  exp_t m;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void model_reset();
    m.take = 0; m.ack = 0; m.err = 0; m.et = 1; m.s = 1; m.ps = 1;
    m.exc = 0; m.pend = 0; m.cwp8 = 0; m.cwp5 = 0; m.tbr = 0; m.pc = 0;
    m.npc = 4; m.d0 = 0; m.d1 = 0; m.we = 0;
  endfunction

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0; tv = 0; irq = 0;
    q.delete();
    @(negedge clk);
    model_reset();
    rst_n = 1'b1;
    m.tag = tag; m.due = cyc;
    q.push_back(m);
  endtask

  // drive one cycle of inputs and queue the expected registered result
  task automatic step(input bit v, input logic [7:0] t, input bit rq, input logic [3:0] l,
                      input logic [3:0] p, input bit e, input bit sv, input logic [2:0] w,
                      input string tag);
    bit sync, fault, irq_ok, enter;
    logic [7:0] tt;
    @(negedge clk);
    tv = v; ttype = t; irq = rq; lvl = l; pil = p; et = e; s = sv; cwp = w;
    irq_ok = (m.pend[7:4] == 4'h1) && (m.pend[3:0] != 0) && e &&
             ((m.pend[3:0] == 4'hf) || (m.pend[3:0] > p));
    sync = !m.err && v && e;
    fault = !m.err && v && !e;
    irq_ok = !m.err && !v && irq_ok;
    enter = sync || irq_ok;
    tt = v ? t : m.pend;
    m.take = enter; m.ack = irq_ok; m.err = m.err | fault; m.we = enter ? 2'b11 : 2'b00;
    if (enter) begin
      m.exc = tt; m.et = 0; m.s = 1; m.ps = sv;
      m.cwp8 = (w == 0) ? 3'd7 : w - 3'd1;
      m.cwp5 = (w == 0) ? 3'd4 : w - 3'd1;
      m.tbr = {tbr[31:12], tt, 4'h0}; m.pc = m.tbr; m.npc = m.tbr + 32'd4;
      m.d0 = pc; m.d1 = npc;
    end
    if (rq && l != 0) m.pend = {4'h1, l};
    else if (irq_ok) m.pend = 8'h00;
    m.tag = tag; m.due = cyc + 1;
    q.push_back(m);
  endtask

  task automatic idle(input string tag);
    step(0, 8'h00, 0, 4'h0, pil, et, s, cwp, tag);
  endtask

  function automatic void cmp1(input string tag, input string f, input logic [31:0] act,
                               input logic [31:0] exp, inout bit bad);
    if (act !== exp) begin
      $display("FAIL %s %s actual=%h expected=%h", tag, f, act, exp);
      bad = 1'b1;
    end
  endfunction

  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = 1'b0;
      cmp1(e.tag, "take", {31'b0, a_take}, {31'b0, e.take}, bad);
      cmp1(e.tag, "ack", {31'b0, a_ack}, {31'b0, e.ack}, bad);
      cmp1(e.tag, "err", {31'b0, a_err}, {31'b0, e.err}, bad);
      cmp1(e.tag, "et", {31'b0, a_et}, {31'b0, e.et}, bad);
      cmp1(e.tag, "s", {31'b0, a_s}, {31'b0, e.s}, bad);
      cmp1(e.tag, "ps", {31'b0, a_ps}, {31'b0, e.ps}, bad);
      cmp1(e.tag, "exc", {24'b0, a_exc}, {24'b0, e.exc}, bad);
      cmp1(e.tag, "pend", {24'b0, a_pend}, {24'b0, e.pend}, bad);
      cmp1(e.tag, "cwp8", {29'b0, a_cwp}, {29'b0, e.cwp8}, bad);
      cmp1(e.tag, "cwp5", {29'b0, b_cwp}, {29'b0, e.cwp5}, bad);
      cmp1(e.tag, "tbr", a_tbr, e.tbr, bad);
      cmp1(e.tag, "pc", a_pc, e.pc, bad);
      cmp1(e.tag, "npc", a_npc, e.npc, bad);
      cmp1(e.tag, "we", {30'b0, a_we}, {30'b0, e.we}, bad);
      cmp1(e.tag, "w5_we", {30'b0, b_we}, {30'b0, e.we}, bad);
      cmp1(e.tag, "w5_take", {31'b0, b_take}, {31'b0, e.take}, bad);
      cmp1(e.tag, "w5_pc", b_pc, e.pc, bad);
      if (e.we == 2'b11) begin
        cmp1(e.tag, "addr0", {25'b0, a_ad0}, {25'b0, e.cwp8, 4'd9}, bad);
        cmp1(e.tag, "addr1", {25'b0, a_ad1}, {25'b0, e.cwp8, 4'd10}, bad);
        cmp1(e.tag, "w5_addr0", {25'b0, b_ad0}, {25'b0, e.cwp5, 4'd9}, bad);
        cmp1(e.tag, "w5_addr1", {25'b0, b_ad1}, {25'b0, e.cwp5, 4'd10}, bad);
        cmp1(e.tag, "data0", a_d0, e.d0, bad);
        cmp1(e.tag, "data1", a_d1, e.d1, bad);
        cmp1(e.tag, "w5_data1", b_d1, e.d1, bad);
      end
      n_chk++;
      if (bad) n_fail++;
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      $display("FAIL watchdog expired actual=running expected=finished");
      n_fail++;
      n_chk++;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    tbr = 32'hABCDE123; pc = 32'h0000_1000; npc = 32'h0000_1004;
    model_reset();
    repeat (2) @(negedge clk);
    do_reset("R10_reset");
    // basic synchronous trap: R2 R3 R4 R5 R6
    step(1, 8'h05, 0, 0, 4'h0, 1, 0, 3'd3, "R2_R3_R4_R5_R6_sync");
    idle("R10_pulse_drop");
    // window wrap at 0
    pc = 32'h0000_2220; npc = 32'h0000_2224; tbr = 32'h1234_5FFF;
    step(1, 8'h2A, 0, 0, 4'h0, 1, 1, 3'd0, "R2_wrap");
    step(1, 8'h81, 0, 0, 4'hF, 1, 0, 3'd4, "R9_pil_ignored");
    idle("R4_hold");
    // interrupt below mask stays pending
    step(0, 8'h00, 1, 4'h5, 4'h7, 1, 0, 3'd2, "R7_latch");
    idle("R7_masked");
    idle("R7_still_pending");
    // lower the mask: accepted
    step(0, 8'h00, 0, 0, 4'h4, 1, 0, 3'd2, "R8_accept");
    idle("R8_pend_cleared");
    // level 15 through a full mask
    step(0, 8'h00, 1, 4'hF, 4'hF, 1, 1, 3'd1, "R7_nmi_latch");
    idle("R7_nmi_taken");
    // level 0 ignored
    step(0, 8'h00, 1, 4'h0, 4'h0, 1, 0, 3'd1, "R7_level0");
    idle("R7_level0_none");
    // traps disabled blocks interrupt
    step(0, 8'h00, 1, 4'h3, 4'h2, 0, 0, 3'd6, "R7_et_latch");
    idle("R7_et_blocked");
    step(0, 8'h00, 0, 0, 4'h2, 1, 0, 3'd6, "R7_et_release");
    idle("R8_after_release");
    // sync trap beats pending interrupt
    step(0, 8'h00, 1, 4'h9, 4'h0, 1, 0, 3'd5, "R9_latch");
    step(1, 8'h07, 0, 0, 4'h0, 1, 0, 3'd5, "R9_sync_wins");
    idle("R9_irq_after");
    idle("R9_quiet");
    // error state
    step(1, 8'h09, 0, 0, 4'h0, 0, 0, 3'd2, "R1_fault");
    step(1, 8'h0A, 0, 0, 4'h0, 1, 0, 3'd2, "R1_no_take");
    step(0, 8'h00, 1, 4'hF, 4'h0, 1, 0, 3'd2, "R1_irq_latch");
    idle("R1_irq_blocked");
    idle("R1_sticky");
    do_reset("R10_reset_clears_err");
    step(1, 8'h11, 0, 0, 4'h0, 1, 0, 3'd7, "R3_after_reset");
    idle("R10_final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule